// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block maps CPU addresses onto bus addresses for the outbound side of a root port. Software reaches up to eight translation slots through one indirect window. It first writes a selector register that names a slot and a direction. It then writes or reads that slot's fields at a small set of fixed offsets. Each slot holds a 64-bit start address, a 32-bit inclusive end for the low word, a 64-bit destination, a transaction kind, a hint flag, a message code, an enable and a shift-mode flag.

On the request side, each valid 64-bit CPU address is compared with every enabled slot in parallel. One cycle later the block reports a hit with the translated address and the transaction kind, or it reports a miss. For the two configuration kinds, shift mode repacks the offset so that the bus/device/function bits land in the upper half of the low word. Software can then lay a configuration space out densely in CPU space while the bus sees the standard layout.

Top module: `outbound_atu`

## Requirements
- R1: A write to offset 0x900 stores bit 31 as the direction (1 = inbound, 0 = outbound) and bits [2:0] as the slot index. A read of 0x900 returns those two fields in the same positions, with all other bits zero. After reset it reads 0.
- R2: With an outbound direction selected, the fields at 0x904..0x91C read back as written. 0x904 holds the kind in bits [4:0] and the hint in bit 12. 0x908 holds the enable in bit 31, shift mode in bit 28 and the message code in bits [7:0]. All other bits of these two words read 0. 0x90C/0x910 hold the start address low/high, 0x914 the end, and 0x918/0x91C the destination low/high, each 32 bits wide.
- R3: With the inbound direction selected, the slot offsets read 0 and writes to them change no slot. Any offset other than 0x900..0x91C reads 0.
- R4: A slot matches when it is enabled, address bits [63:32] equal its high start word, and bits [31:0] lie between its low start word and its end, both ends included.
- R5: Outside shift mode, the translated address is the 64-bit destination plus (address[31:0] − low start word), with the carry propagated into the upper word.
- R6: When several slots match, the lowest-numbered slot supplies the result.
- R7: In shift mode for kind 0x4 or 0x5, the result is {dest high, off[27:12], 4'b0000, off[11:0]}, where off is the offset from the start address and the low destination word is not used.
- R8: The shift flag has no effect on kinds other than 0x4 and 0x5, for example memory kind 0x0 or I/O kind 0x2.
- R9: A miss gives rspMiss=1, rspHit=0, a zero address and a zero kind.
- R10: Every request cycle produces exactly one response in the following cycle, including back-to-back requests.
- R11: A field write is used by the next request, whether or not the slot is enabled at that moment.
- R12: After reset every slot is disabled, so any request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| reqValid | input | 1 | Translation request valid |
| reqAddr | input | 64 | CPU address to translate |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspHit | output | 1 | A slot matched |
| rspMiss | output | 1 | No slot matched |
| rspAddr | output | 64 | Translated bus address |
| rspType | output | 5 | Transaction kind of the matching slot |

## Verification
The bench sends addresses at the exact low start and high end of a window, and one byte beyond each. This separates an inclusive compare from an exclusive one, and a high-word mismatch from a low-word range miss. A slot whose destination low word sits near 2^32 shows whether the carry reaches the upper word. Overlapping slots, probed before and after the lower slot is disabled, confirm the priority order. Both configuration kinds with shift mode are tried, alongside a memory slot that has the same flag set, which separates repacking by kind from repacking by flag. Inbound writes, back-to-back requests and a write to a disabled slot cover the selector and ordering corners.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_ADDR_W = 12;
  localparam int IDX_W      = 3;   // width of the selector's slot index field
  localparam int KIND_W     = 5;
  localparam int MSG_W      = 8;
  localparam int NUM_FIELDS = 7;

  localparam int VIEW_DIR_BIT = 31;
  localparam int HINT_BIT     = 12;
  localparam int EN_BIT       = 31;
  localparam int SHIFT_BIT    = 28;

  localparam logic [REG_ADDR_W-1:0] OFF_VIEW    = 12'h900;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL1   = 12'h904;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL2   = 12'h908;
  localparam logic [REG_ADDR_W-1:0] OFF_BASE_LO = 12'h90C;
  localparam logic [REG_ADDR_W-1:0] OFF_BASE_HI = 12'h910;
  localparam logic [REG_ADDR_W-1:0] OFF_LIMIT   = 12'h914;
  localparam logic [REG_ADDR_W-1:0] OFF_TGT_LO  = 12'h918;
  localparam logic [REG_ADDR_W-1:0] OFF_TGT_HI  = 12'h91C;

  localparam logic [KIND_W-1:0] KIND_MEM  = 5'h0;
  localparam logic [KIND_W-1:0] KIND_IO   = 5'h2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 5'h4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 5'h5;

  typedef enum logic [2:0] {
    FLD_CTRL1, FLD_CTRL2, FLD_BASE_LO, FLD_BASE_HI, FLD_LIMIT, FLD_TGT_LO, FLD_TGT_HI
  } fieldE;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              hint;
    logic              en;
    logic              shift;
    logic [MSG_W-1:0]  msg;
    logic [DATA_W-1:0] baseLo;
    logic [DATA_W-1:0] baseHi;
    logic [DATA_W-1:0] limit;
    logic [DATA_W-1:0] tgtLo;
    logic [DATA_W-1:0] tgtHi;
  } regionT;

  typedef struct packed {
    logic                  wrEn;
    logic [IDX_W-1:0]      idx;
    logic [NUM_FIELDS-1:0] fieldSel;
    logic [DATA_W-1:0]     data;
  } wrStrbT;
endpackage

// File: rtl/atu_regctl.sv
module atu_regctl
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  regionT                selView,
  output logic [IDX_W-1:0]      selIdx,
  output wrStrbT                wrStrb
);
  logic                  vpInbound;
  logic [IDX_W-1:0]      vpIdx;
  logic                  idxOk;
  logic                  windowOk;
  logic [NUM_FIELDS-1:0] fieldDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpInbound <= 1'b0;
      vpIdx     <= '0;
    end else if (regWe && regAddr == OFF_VIEW) begin
      vpInbound <= regWdata[VIEW_DIR_BIT];
      vpIdx     <= regWdata[IDX_W-1:0];
    end
  end

  assign idxOk    = (32'(vpIdx) < 32'(NUM_REGIONS));
  assign windowOk = !vpInbound && idxOk;
  assign selIdx   = vpIdx;

  always_comb begin
    fieldDec = '0;
    case (regAddr)
      OFF_CTRL1:   fieldDec[FLD_CTRL1]   = 1'b1;
      OFF_CTRL2:   fieldDec[FLD_CTRL2]   = 1'b1;
      OFF_BASE_LO: fieldDec[FLD_BASE_LO] = 1'b1;
      OFF_BASE_HI: fieldDec[FLD_BASE_HI] = 1'b1;
      OFF_LIMIT:   fieldDec[FLD_LIMIT]   = 1'b1;
      OFF_TGT_LO:  fieldDec[FLD_TGT_LO]  = 1'b1;
      OFF_TGT_HI:  fieldDec[FLD_TGT_HI]  = 1'b1;
      default:     fieldDec = '0;
    endcase
  end

  always_comb begin
    wrStrb.wrEn     = regWe && windowOk && (|fieldDec);
    wrStrb.idx      = vpIdx;
    wrStrb.fieldSel = wrStrb.wrEn ? fieldDec : '0;
    wrStrb.data     = regWdata;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == OFF_VIEW) begin
      regRdata = {vpInbound, {(DATA_W-1-IDX_W){1'b0}}, vpIdx};
    end else if (windowOk) begin
      case (regAddr)
        OFF_CTRL1:   regRdata = {19'b0, selView.hint, 7'b0, selView.kind};
        OFF_CTRL2:   regRdata = {selView.en, 2'b0, selView.shift, 20'b0, selView.msg};
        OFF_BASE_LO: regRdata = selView.baseLo;
        OFF_BASE_HI: regRdata = selView.baseHi;
        OFF_LIMIT:   regRdata = selView.limit;
        OFF_TGT_LO:  regRdata = selView.tgtLo;
        OFF_TGT_HI:  regRdata = selView.tgtHi;
        default:     regRdata = '0;
      endcase
    end
  end

  // R1: a selector write is captured for the next cycle
  p_view_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFF_VIEW) |=>
      (vpIdx == $past(regWdata[IDX_W-1:0]) && vpInbound == $past(regWdata[VIEW_DIR_BIT])));

  // R3: nothing but the selector offset returns data while inbound is selected
  p_inbound_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vpInbound && regAddr != OFF_VIEW) |-> (regRdata == '0));
endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrbT             wrStrb,
  input  logic [IDX_W-1:0]   selIdx,
  output regionT             selView,
  input  logic               reqValid,
  input  logic [2*DATA_W-1:0] reqAddr,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspMiss,
  output logic [2*DATA_W-1:0] rspAddr,
  output logic [KIND_W-1:0]  rspType
);
  localparam int ADDR_W = 2 * DATA_W;

  regionT [NUM_REGIONS-1:0] regionQ;
  logic   [NUM_REGIONS-1:0] matchVec;
  logic   [NUM_REGIONS-1:0] enMask;

  logic              winHit;
  regionT            winRegion;
  logic [DATA_W-1:0] offset;
  logic              useShift;
  logic [ADDR_W-1:0] linAddr;
  logic [ADDR_W-1:0] shiftAddr;
  logic [ADDR_W-1:0] nextAddr;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regionQ[r] <= '0;
      end else if (wrStrb.wrEn && wrStrb.idx == IDX_W'(r)) begin
        if (wrStrb.fieldSel[FLD_CTRL1]) begin
          regionQ[r].kind <= wrStrb.data[KIND_W-1:0];
          regionQ[r].hint <= wrStrb.data[HINT_BIT];
        end
        if (wrStrb.fieldSel[FLD_CTRL2]) begin
          regionQ[r].en    <= wrStrb.data[EN_BIT];
          regionQ[r].shift <= wrStrb.data[SHIFT_BIT];
          regionQ[r].msg   <= wrStrb.data[MSG_W-1:0];
        end
        if (wrStrb.fieldSel[FLD_BASE_LO]) regionQ[r].baseLo <= wrStrb.data;
        if (wrStrb.fieldSel[FLD_BASE_HI]) regionQ[r].baseHi <= wrStrb.data;
        if (wrStrb.fieldSel[FLD_LIMIT])   regionQ[r].limit  <= wrStrb.data;
        if (wrStrb.fieldSel[FLD_TGT_LO])  regionQ[r].tgtLo  <= wrStrb.data;
        if (wrStrb.fieldSel[FLD_TGT_HI])  regionQ[r].tgtHi  <= wrStrb.data;
      end
    end

    assign enMask[r]   = regionQ[r].en;
    assign matchVec[r] = regionQ[r].en
                      && (reqAddr[ADDR_W-1:DATA_W] == regionQ[r].baseHi)
                      && (reqAddr[DATA_W-1:0] >= regionQ[r].baseLo)
                      && (reqAddr[DATA_W-1:0] <= regionQ[r].limit);
  end

  always_comb begin
    selView = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (selIdx == IDX_W'(r)) selView = regionQ[r];
    end
  end

  // Scan from the top so that the lowest matching slot is assigned last.
  always_comb begin
    winHit    = 1'b0;
    winRegion = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (matchVec[r]) begin
        winHit    = 1'b1;
        winRegion = regionQ[r];
      end
    end
  end

  assign offset    = reqAddr[DATA_W-1:0] - winRegion.baseLo;
  assign useShift  = winRegion.shift &&
                     (winRegion.kind == KIND_CFG0 || winRegion.kind == KIND_CFG1);
  assign linAddr   = {winRegion.tgtHi, winRegion.tgtLo} + {{DATA_W{1'b0}}, offset};
  assign shiftAddr = {winRegion.tgtHi, offset[27:12], 4'b0000, offset[11:0]};
  assign nextAddr  = useShift ? shiftAddr : linAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspAddr  <= '0;
      rspType  <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= reqValid && winHit;
      rspMiss  <= reqValid && !winHit;
      rspAddr  <= (reqValid && winHit) ? nextAddr : '0;
      rspType  <= (reqValid && winHit) ? winRegion.kind : '0;
    end
  end

  // R10: one response for every request cycle, one cycle later
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R12: with no slot enabled every request misses
  p_none_enabled_miss_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && enMask == '0) |=> (rspMiss && !rspHit));

  // R9: a miss carries a zero address and kind
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspAddr == '0 && rspType == '0 && !rspHit));

  // R2: the control side selects at most one field per write
  p_one_field_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrb.fieldSel));

  // R11: slot storage changes only on a write strobe
  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrb.wrEn |=> $stable(regionQ));
endmodule

// File: rtl/outbound_atu.sv
module outbound_atu
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        reqValid,
  input  logic [63:0] reqAddr,
  output logic        rspValid,
  output logic        rspHit,
  output logic        rspMiss,
  output logic [63:0] rspAddr,
  output logic [4:0]  rspType
);
  wrStrbT           wrStrb;
  regionT           selView;
  logic [IDX_W-1:0] selIdx;

  atu_regctl #(.NUM_REGIONS(NUM_REGIONS)) i_regctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .selView(selView),
    .selIdx(selIdx), .wrStrb(wrStrb)
  );

  atu_xlate #(.NUM_REGIONS(NUM_REGIONS)) i_xlate (
    .clk(clk), .rstN(rstN), .wrStrb(wrStrb), .selIdx(selIdx),
    .selView(selView), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspAddr(rspAddr), .rspType(rspType)
  );
endmodule

// File: tb/test_outbound_atu.sv
module test_outbound_atu;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid, rspHit, rspMiss;
  logic [63:0] rspAddr;
  logic [4:0]  rspType;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  typedef struct {
    bit          hit;
    logic [63:0] addr;
    logic [4:0]  kind;
    string       tag;
  } expT;
  expT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  outbound_atu i_outbound_atu (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit),
    .rspMiss(rspMiss), .rspAddr(rspAddr), .rspType(rspType)
  );

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      nRun++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R10 unexpected response: actual addr=%h expected none", rspAddr);
      end else begin
        expT e;
        e = expQ.pop_front();
        if (rspHit !== e.hit || rspMiss !== !e.hit || rspAddr !== e.addr || rspType !== e.kind) begin
          nFail++;
          $display("FAIL %s actual hit=%0b miss=%0b addr=%h kind=%h expected hit=%0b addr=%h kind=%h",
                   e.tag, rspHit, rspMiss, rspAddr, rspType, e.hit, e.addr, e.kind);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    nRun++;
    if (regRdata !== exp) begin
      nFail++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, regRdata, exp);
    end
  endtask

  // driver: holds reqValid for one cycle per call and queues the expectation
  task automatic req(input logic [63:0] a, input bit hit, input logic [63:0] ea,
                     input logic [4:0] ek, input string tag);
    expT e;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    e.hit = hit; e.addr = ea; e.kind = ek; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [31:0] c1, input logic [31:0] c2,
                      input logic [31:0] bHi, input logic [31:0] bLo, input logic [31:0] lim,
                      input logic [31:0] tHi, input logic [31:0] tLo);
    wr(12'h900, 32'(idx));
    wr(12'h904, c1);
    wr(12'h90C, bLo);
    wr(12'h910, bHi);
    wr(12'h914, lim);
    wr(12'h918, tLo);
    wr(12'h91C, tHi);
    wr(12'h908, c2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 / R1: reset state
    rdChk(12'h900, 32'h0, "R1");
    req(64'h0000_0001_1000_0000, 0, 64'h0, 5'h0, "R12");
    idle();

    // R2: field packing, slot 7 left disabled
    wr(12'h900, 32'h7);
    wr(12'h904, 32'hFFFF_FFFF);
    rdChk(12'h904, 32'h0000_101F, "R2");
    wr(12'h908, 32'h0000_00FF);
    rdChk(12'h908, 32'h0000_00FF, "R2");
    wr(12'h904, 32'h0);
    wr(12'h90C, 32'h3000_0000);
    wr(12'h914, 32'h3000_FFFF);
    rdChk(12'h914, 32'h3000_FFFF, "R2");

    prog(0, 32'h0,    32'h8000_0000, 32'h1, 32'h1000_0000, 32'h1000_FFFF, 32'h0,         32'h8000_0000);
    prog(1, 32'h4,    32'h9000_0000, 32'h0, 32'h6000_0000, 32'h6000_FFFF, 32'h0,         32'h0);
    prog(2, 32'h5,    32'h9000_0000, 32'h0, 32'h6001_0000, 32'h6FFF_FFFF, 32'h7,         32'hAAAA_0000);
    prog(3, 32'h1002, 32'h8000_0000, 32'h0, 32'h7000_0000, 32'h7000_FFFF, 32'h1000_0000, 32'h0);
    prog(4, 32'h0,    32'h8000_0000, 32'h1, 32'h1000_0000, 32'h1000_0FFF, 32'hDEAD_0000, 32'h0);
    prog(5, 32'h0,    32'h9000_0000, 32'h0, 32'h4000_0000, 32'h4000_0FFF, 32'h0,         32'h5000_0000);
    prog(6, 32'h0,    32'h8000_0000, 32'h0, 32'h2000_0000, 32'h2000_FFFF, 32'h1,         32'hFFFF_F000);

    rdChk(12'h900, 32'h0000_0006, "R1");
    wr(12'h900, 32'h3);
    rdChk(12'h904, 32'h0000_1002, "R2");
    rdChk(12'h91C, 32'h1000_0000, "R2");

    // R4 boundaries of slot 0, R6 priority over slot 4
    req(64'h0000_0001_1000_0000, 1, 64'h0000_0000_8000_0000, 5'h0, "R4 low end");
    req(64'h0000_0001_1000_FFFF, 1, 64'h0000_0000_8000_FFFF, 5'h0, "R4 high end");
    req(64'h0000_0001_1001_0000, 0, 64'h0, 5'h0, "R4 above end");
    req(64'h0000_0001_0FFF_FFFF, 0, 64'h0, 5'h0, "R4 below start");
    req(64'h0000_0000_1000_0800, 0, 64'h0, 5'h0, "R4 high word");
    req(64'h0000_0001_1000_0800, 1, 64'h0000_0000_8000_0800, 5'h0, "R6");
    req(64'h0000_0000_3000_0000, 0, 64'h0, 5'h0, "R4 disabled");
    // R7 shift mode for both configuration kinds
    req(64'h0000_0000_6000_1234, 1, 64'h0000_0000_0001_0234, 5'h4, "R7 cfg0");
    req(64'h0000_0000_6123_4567, 1, 64'h0000_0007_1224_0567, 5'h5, "R7 cfg1");
    // R8 shift flag ignored for memory; I/O path
    req(64'h0000_0000_4000_0ABC, 1, 64'h0000_0000_5000_0ABC, 5'h0, "R8");
    req(64'h0000_0000_7000_0010, 1, 64'h1000_0000_0000_0010, 5'h2, "R8 io");
    // R5 carry into the upper word
    req(64'h0000_0000_2000_1010, 1, 64'h0000_0002_0000_0010, 5'h0, "R5");
    idle();
    req(64'h0000_0000_6FFF_FFFF, 1, 64'h0000_0007_FFEF_0FFF, 5'h5, "R9 R10 single");
    idle();

    // R3: inbound selection hides and protects slots
    wr(12'h900, 32'hFFFF_FFFF);
    rdChk(12'h900, 32'h8000_0007, "R1");
    rdChk(12'h90C, 32'h0, "R3");
    wr(12'h900, 32'h8000_0000);
    wr(12'h90C, 32'h1234_5678);
    wr(12'h908, 32'h0);
    rdChk(12'h908, 32'h0, "R3");
    wr(12'h900, 32'h0);
    rdChk(12'h90C, 32'h1000_0000, "R3");
    rdChk(12'h908, 32'h8000_0000, "R3");
    rdChk(12'h920, 32'h0, "R3");
    rdChk(12'h000, 32'h0, "R3");
    req(64'h0000_0001_1000_0000, 1, 64'h0000_0000_8000_0000, 5'h0, "R3 slot intact");
    idle();

    // R6: disable slot 0, slot 4 takes over
    wr(12'h908, 32'h0);
    req(64'h0000_0001_1000_0800, 1, 64'hDEAD_0000_0000_0800, 5'h0, "R6 fallback");
    idle();

    // R11: write a disabled slot, then enable it
    wr(12'h918, 32'h9000_0000);
    wr(12'h908, 32'h8000_0000);
    req(64'h0000_0001_1000_0010, 1, 64'h0000_0000_9000_0010, 5'h0, "R11 retarget");
    idle();
    wr(12'h900, 32'h7);
    wr(12'h908, 32'h8000_0000);
    req(64'h0000_0000_3000_0004, 1, 64'h0000_0000_0000_0004, 5'h0, "R11 enable");
    idle();

    repeat (3) @(negedge clk);
    nRun++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule